// File: doc/BRIEF.md
# Receive Destination Address Filter

This block decides, from the first 16-bit word of an incoming Ethernet packet, whether the receiver keeps the packet or skips to the next one. The destination host number is the upper byte of that word. A signed 16-bit host register selects the matching scheme. When it is non-negative, the filter accepts three kinds of packet: broadcast packets, packets sent to its own host number, and any packet at all when the register is zero (promiscuous). When it is negative, the filter looks the destination up in a 256-bit membership vector, which is stored as sixteen 16-bit words.

Software loads the vector words and the host register through a small address/data/write-enable port. The receive datapath presents the first packet word with a valid strobe, together with a flag that says whether a receive buffer is available. One cycle later the filter returns a done pulse, an accept flag and a skip flag. When no buffer is available, the packet is dropped and a wrapping missed-packet counter is incremented.

Top module: `rx_dest_filter`

## Requirements
- R1: After reset, decide_done, decide_accept and skip_pkt are 0, missed_count is 0, the host register is 0 and every vector word is 0.
- R2: decide_done is 1 for exactly the one cycle after a cycle in which word_valid was 1 at a rising clock edge, and 0 otherwise.
- R3: With a non-negative host register, a destination of 0 (word_data[15:8] == 0) is accepted.
- R4: With a non-negative, non-zero host register, a destination equal to the host register is accepted and any other non-zero destination is rejected.
- R5: With the host register equal to 0, every destination is accepted.
- R6: With a negative host register (bit 15 set), the filter selects vector word destination[7:4] and bit (15 - destination[3:0]) of that word, so position 0 is the MSB. The packet is accepted exactly when that bit is 1.
- R7: In multicast mode, destination 0 is accepted only when bit 15 of vector word 0 is set.
- R8: When buf_avail is 0 at the strobe, the packet is rejected whatever its destination, and missed_count increments by one on the same edge that registers the decision.
- R9: skip_pkt is 1 exactly when decide_done is 1 and decide_accept is 0. decide_accept is never 1 without decide_done.
- R10: missed_count is 16 bits wide and wraps from 16'hFFFF to 0.
- R11: cfg_addr 0 to 15 write vector words 0 to 15, and cfg_addr 16 writes the host register. Writes to addresses 17 to 31 change nothing. A write takes effect for strobes on later cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 5 | Configuration address (0-15 vector words, 16 host register) |
| cfg_wdata | input | 16 | Configuration write data |
| word_valid | input | 1 | First packet word is present |
| word_data | input | 16 | First packet word; destination is bits 15:8 |
| buf_avail | input | 1 | A receive buffer is available for this packet |
| decide_done | output | 1 | One-cycle pulse when the decision is valid |
| decide_accept | output | 1 | Packet accepted |
| skip_pkt | output | 1 | Packet rejected or dropped; skip the rest of it |
| missed_count | output | 16 | Packets dropped because no buffer was available |

## Verification
The bench aims at the bit ordering inside a vector word. It probes the neighbours of a set bit, so a design that indexed from the LSB would accept the wrong host. It also tests broadcast in both modes. A filter that always accepted destination 0 would pass single-host tests but fail in multicast mode while word 0 bit 15 is clear. It writes to unmapped addresses and checks that the host register has not been aliased. It drives 65536 dropped packets so that the missed counter wraps, which exposes a counter that saturates or is too narrow.

// File: rtl/rdf_pkg.sv
// Shared constants and types for the receive destination filter.
// Assumes a 16-bit packet word whose upper byte is the destination host.
package rdf_pkg;
    localparam int WORD_W = 16;
    localparam int HOST_W = 8;

    typedef struct packed {
        logic done;
        logic accept;
        logic skip;
    } decision_t;
endpackage

// File: rtl/rdf_cfg_regs.sv
// Configuration store: NUM_WORDS membership-vector words plus the host register.
// Assumes addresses below NUM_WORDS select vector words, address NUM_WORDS
// selects the host register, and higher addresses are unmapped.
module rdf_cfg_regs #(
    parameter int WORD_W    = 16,
    parameter int NUM_WORDS = 16,
    parameter int AW        = 5
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              we,
    input  logic [AW-1:0]                     addr,
    input  logic [WORD_W-1:0]                 wdata,
    output logic [WORD_W-1:0]                 host_reg,
    output logic [NUM_WORDS-1:0][WORD_W-1:0]  vec_words
);
    localparam logic [AW-1:0] HOST_ADDR = AW'(NUM_WORDS);

    genvar g;
    generate
        for (g = 0; g < NUM_WORDS; g++) begin : g_vec
            // Holds one membership word; loaded when its address is written.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    vec_words[g] <= '0;
                else if (we && addr == AW'(g))
                    vec_words[g] <= wdata;
            end
        end
    endgenerate

    // Holds the signed host number that selects the matching mode.
    always_ff @(posedge clk) begin
        if (!rst_n)
            host_reg <= '0;
        else if (we && addr == HOST_ADDR)
            host_reg <= wdata;
    end

    // R11
    unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr > HOST_ADDR) |=> ($stable(host_reg) && $stable(vec_words)));
endmodule

// File: rtl/rdf_match.sv
// Combinational address match. Non-negative host register: broadcast,
// own-host or promiscuous. Negative host register: membership-vector lookup
// with position 0 at the MSB of each word.
module rdf_match #(
    parameter int WORD_W    = 16,
    parameter int HOST_W    = 8,
    parameter int NUM_WORDS = 16
) (
    input  logic [HOST_W-1:0]                 dest,
    input  logic [WORD_W-1:0]                 host_reg,
    input  logic [NUM_WORDS-1:0][WORD_W-1:0]  vec_words,
    output logic                              hit
);
    localparam int POS_W = $clog2(WORD_W);
    localparam int IDX_W = HOST_W - POS_W;

    logic              multicast;
    logic [IDX_W-1:0]  word_idx;
    logic [POS_W-1:0]  bit_pos;
    logic [WORD_W-1:0] aligned;
    logic              single_hit;

    // Splits the destination and left-justifies the selected vector bit.
    always_comb begin
        multicast  = host_reg[WORD_W-1];
        word_idx   = dest[HOST_W-1:POS_W];
        bit_pos    = dest[POS_W-1:0];
        aligned    = vec_words[word_idx] << bit_pos;
        single_hit = (dest == '0) || (host_reg == '0) ||
                     (host_reg == WORD_W'(dest));
        hit        = multicast ? aligned[WORD_W-1] : single_hit;
    end
endmodule

// File: rtl/rdf_miss_counter.sv
// Wrapping counter of packets dropped for lack of a receive buffer.
module rdf_miss_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] count
);
    // Advances by one per dropped packet, wrapping at 2**W.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (inc)
            count <= count + 1'b1;
    end

    // R10
    miss_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && count == '1) |=> (count == '0));
endmodule

// File: rtl/rx_dest_filter.sv
// Receive destination address filter top. Registers an accept/skip decision
// one cycle after the first-word strobe and counts packets dropped for lack
// of a buffer. Assumes one strobe per packet.
module rx_dest_filter
    import rdf_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [4:0]        cfg_addr,
    input  logic [15:0]       cfg_wdata,
    input  logic              word_valid,
    input  logic [15:0]       word_data,
    input  logic              buf_avail,
    output logic              decide_done,
    output logic              decide_accept,
    output logic              skip_pkt,
    output logic [CNT_W-1:0]  missed_count
);
    localparam int NUM_WORDS = (2 ** HOST_W) / WORD_W;
    localparam int AW        = $clog2(NUM_WORDS) + 1;

    logic [WORD_W-1:0]                host_reg;
    logic [NUM_WORDS-1:0][WORD_W-1:0] vec_words;
    logic                             hit;
    logic                             drop;
    decision_t                        dec_q;

    rdf_cfg_regs #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS), .AW(AW)) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
        .wdata(cfg_wdata), .host_reg(host_reg), .vec_words(vec_words)
    );

    rdf_match #(.WORD_W(WORD_W), .HOST_W(HOST_W), .NUM_WORDS(NUM_WORDS)) u_match (
        .dest(word_data[WORD_W-1 -: HOST_W]), .host_reg(host_reg),
        .vec_words(vec_words), .hit(hit)
    );

    assign drop = word_valid && !buf_avail;

    rdf_miss_counter #(.W(CNT_W)) u_miss (
        .clk(clk), .rst_n(rst_n), .inc(drop), .count(missed_count)
    );

    // Captures the decision for the strobed word, valid for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_q <= '0;
        end else begin
            dec_q.done   <= word_valid;
            dec_q.accept <= word_valid && buf_avail && hit;
            dec_q.skip   <= word_valid && !(buf_avail && hit);
        end
    end

    assign decide_done   = dec_q.done;
    assign decide_accept = dec_q.accept;
    assign skip_pkt      = dec_q.skip;

    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> decide_done);
    // R2
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !word_valid |=> !decide_done);
    // R9
    accept_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        decide_accept |-> (decide_done && !skip_pkt));
    // R8
    no_buffer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> (skip_pkt && missed_count == $past(missed_count) + 1'b1));
    // R8
    miss_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !drop |=> $stable(missed_count));
    // R3
    broadcast_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && buf_avail && !host_reg[WORD_W-1] &&
         word_data[15:8] == '0) |=> decide_accept);
    // R5
    promiscuous_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && buf_avail && host_reg == '0) |=> decide_accept);
endmodule

// File: tb/rx_dest_filter_tb.sv
module rx_dest_filter_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic        word_valid = 1'b0;
    logic [15:0] word_data = '0;
    logic        buf_avail = 1'b1;
    logic        decide_done, decide_accept, skip_pkt;
    logic [15:0] missed_count;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    logic [15:0] exp_miss = '0;

    rx_dest_filter u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .word_valid(word_valid), .word_data(word_data),
        .buf_avail(buf_avail), .decide_done(decide_done),
        .decide_accept(decide_accept), .skip_pkt(skip_pkt),
        .missed_count(missed_count)
    );

    always #2 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected<190000", cycles);
            finish_run();
        end
    end

    task automatic cfg_write(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Strobes one word and checks done/accept/skip one cycle later.
    task automatic packet(input string req, input logic [7:0] dest,
                          input logic avail, input logic exp_acc);
        @(negedge clk);
        word_valid = 1'b1; word_data = {dest, 8'h5A}; buf_avail = avail;
        if (!avail) exp_miss = exp_miss + 1'b1;
        @(negedge clk);
        word_valid = 1'b0; buf_avail = 1'b1;
        check({req, " done"}, decide_done, 1'b1);
        check({req, " accept"}, decide_accept, exp_acc);
        check({req, " skip"}, skip_pkt, !exp_acc);
        @(negedge clk);
        check("R2 done one cycle", decide_done, 1'b0);
    endtask

    task automatic t_reset();
        check("R1 done", decide_done, 1'b0);
        check("R1 accept", decide_accept, 1'b0);
        check("R1 skip", skip_pkt, 1'b0);
        check("R1 missed", missed_count, 16'h0);
        packet("R1 R5 reset host 0 promiscuous", 8'h37, 1'b1, 1'b1);
    endtask

    task automatic t_single();
        cfg_write(5'd16, 16'h0005);
        packet("R3 broadcast", 8'h00, 1'b1, 1'b1);
        packet("R4 own host", 8'h05, 1'b1, 1'b1);
        packet("R4 other host", 8'h06, 1'b1, 1'b0);
        packet("R4 other host hi", 8'h85, 1'b1, 1'b0);
        cfg_write(5'd16, 16'h0000);
        packet("R5 promiscuous", 8'hC3, 1'b1, 1'b1);
    endtask

    task automatic t_multi();
        cfg_write(5'd3, 16'h2000);
        cfg_write(5'd15, 16'h0001);
        cfg_write(5'd16, 16'hFFFF);
        packet("R6 member 0x32", 8'h32, 1'b1, 1'b1);
        packet("R6 neighbour 0x33", 8'h33, 1'b1, 1'b0);
        packet("R6 neighbour 0x31", 8'h31, 1'b1, 1'b0);
        packet("R6 mirrored 0x3D", 8'h3D, 1'b1, 1'b0);
        packet("R6 last host 0xFF", 8'hFF, 1'b1, 1'b1);
        packet("R7 broadcast clear", 8'h00, 1'b1, 1'b0);
        cfg_write(5'd0, 16'h8000);
        packet("R7 broadcast set", 8'h00, 1'b1, 1'b1);
        cfg_write(5'd16, 16'h8000);
        packet("R6 other negative host", 8'h32, 1'b1, 1'b1);
    endtask

    task automatic t_unmapped();
        cfg_write(5'd17, 16'h0000);
        cfg_write(5'd31, 16'hFFFF);
        packet("R11 host unchanged", 8'h33, 1'b1, 1'b0);
        packet("R11 vector unchanged", 8'h32, 1'b1, 1'b1);
    endtask

    task automatic t_no_buffer();
        packet("R8 member no buffer", 8'h32, 1'b0, 1'b0);
        check("R8 missed count", missed_count, exp_miss);
        packet("R8 second drop", 8'h00, 1'b0, 1'b0);
        check("R8 missed count 2", missed_count, exp_miss);
    endtask

    task automatic t_wrap();
        @(negedge clk);
        word_valid = 1'b1; buf_avail = 1'b0; word_data = 16'h1200;
        while (exp_miss != 16'hFFFF) begin
            @(negedge clk);
            exp_miss = exp_miss + 1'b1;
        end
        word_valid = 1'b0; buf_avail = 1'b1;
        check("R10 reach max", missed_count, 16'hFFFF);
        packet("R10 wrap", 8'h32, 1'b0, 1'b0);
        check("R10 wrapped to zero", missed_count, 16'h0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_multi();
        t_unmapped();
        t_no_buffer();
        t_wrap();
        finish_run();
    end
endmodule